// File: doc/BRIEF.md
# Shared Interrupt Routing Table

This block keeps one routing entry for every shared interrupt of an interrupt controller. An entry holds the target processor affinity that software last wrote. It also holds a resolved CPU index, which is a valid CPU number or a reserved "nobody" code. Software reaches the entries through a register window in which each entry is 8 bytes wide. Only the lower 32-bit half of an entry holds state.

On every accepted write, the block compares the written affinity against a table of the affinities of the CPUs that exist. The whole compare happens in the same cycle as the write. The block then moves the interrupt's bit from the bitmap of the old target CPU to the bitmap of the new one. Downstream logic uses the per-CPU target bitmaps and the per-interrupt CPU index to decide where a pending shared interrupt goes.

An affinity that matches no CPU is still stored and reads back unchanged. Such an interrupt is targeted at no CPU at all, so it can still become pending but is never delivered.

Top module: `spi_route_table`

## Requirements
- R1: While reset is held, every entry takes the affinity of CPU 0 (`cpu_aff_i[31:0]`), every resolved index becomes 0, the bitmap of CPU 0 becomes all ones, and every other CPU bitmap becomes zero.
- R2: The entry index is the byte offset divided by 8. A read of the lower half (offset bit 2 = 0) returns, one cycle after `rd_en`, the 32-bit value last written, exactly as written. The value is packed with affinity level 0 in bits 7:0 through level 3 in bits 31:24.
- R3: A read of the upper half (offset bit 2 = 1) returns zero. A write to the upper half changes no entry, no index and no bitmap, and does not raise `upd_o`.
- R4: A write whose affinity equals the affinity of CPU k sets the resolved index to k and sets the interrupt's bit in CPU k's bitmap. It also clears the interrupt's bit from the bitmap of the previously resolved CPU. All of this is visible in the cycle after the write.
- R5: A write whose affinity matches no CPU sets the resolved index to 0xFF and leaves the interrupt's bit clear in every bitmap. The written value still reads back unchanged.
- R6: When several CPUs share the written affinity, the lowest-numbered of them is chosen.
- R7: `upd_o` is high for exactly the one cycle that follows each accepted write, meaning a lower-half write to an entry that exists. It is low at all other times.
- R8: Offsets that lie past the last entry read as zero, and writes to them have no effect and raise no strobe.
- R9: Each interrupt is set in at most one CPU bitmap. That CPU is always the one named by its resolved index, and no bitmap holds the bit when the index is 0xFF.
- R10: Writing the affinity of the CPU that is already the target leaves that CPU's bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_aff_i | input | NUM_CPUS*32 | Affinity of each existing CPU; CPU c occupies bits 32c+31:32c |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset into the routing window |
| wdata | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered, valid the cycle after `rd_en` |
| upd_o | output | 1 | One-cycle pulse after each accepted routing write |
| target_map_o | output | NUM_CPUS*NUM_SHARED | CPU c's target bitmap in bits c*NUM_SHARED +: NUM_SHARED |
| cpu_idx_o | output | NUM_SHARED*8 | Resolved CPU index of interrupt s in bits 8s +: 8, 0xFF for nobody |

## Verification
Every result of this block sits exactly one register away from its stimulus. The strobe, the resolved index and both affected bitmap bits change on the clock edge that accepts a write. Read data appears on the edge that samples `rd_en`. The bench drives inputs on the falling edge and samples on the next falling edge, which is half a cycle after the single edge that matters. It then checks one more cycle later that the strobe has dropped and that the bitmaps have not moved without a write.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int AFF_W = 32;
  localparam int IDX_W = 8;
  typedef logic [AFF_W-1:0] aff_t;
  typedef logic [IDX_W-1:0] idx_t;
  // reserved index code: interrupt targets no CPU
  localparam idx_t IDX_NONE = 8'hFF;
endpackage

// File: rtl/rt_addr_dec.sv
module rt_addr_dec #(
  parameter int ADDR_W     = 12,
  parameter int NUM_SHARED = 32,
  parameter int SH_IW      = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SH_IW-1:0]  slot,
  output logic              hi_half,
  output logic              in_range
);
  localparam int ENT_W = ADDR_W - 3;
  localparam logic [ENT_W:0] LIMIT = NUM_SHARED[ENT_W:0];

  logic [ENT_W-1:0] ent;
  logic [1:0]       unused_byte;

  // 8 bytes per entry; bit 2 picks the half, bits 1:0 are byte lanes
  assign ent         = addr[ADDR_W-1:3];
  assign hi_half     = addr[2];
  assign unused_byte = addr[1:0];
  assign in_range    = ({1'b0, ent} < LIMIT);
  assign slot        = ent[SH_IW-1:0];
endmodule

// File: rtl/rt_aff_match.sv
module rt_aff_match
  import rt_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  aff_t                      key,
  input  logic [NUM_CPUS*AFF_W-1:0] table_i,
  output logic                      hit,
  output idx_t                      idx
);
  logic [NUM_CPUS-1:0] eq;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cmp
    assign eq[c] = (table_i[c*AFF_W +: AFF_W] == key);
  end

  // scan downward so the lowest matching CPU is the last one assigned
  always_comb begin
    hit = |eq;
    idx = IDX_NONE;
    for (int c = NUM_CPUS - 1; c >= 0; c--) begin
      if (eq[c]) idx = idx_t'(c);
    end
  end
endmodule

// File: rtl/spi_route_table.sv
module spi_route_table
  import rt_pkg::*;
#(
  parameter int NUM_SHARED = 32,
  parameter int NUM_CPUS   = 4,
  parameter int ADDR_W     = 12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CPUS*32-1:0]         cpu_aff_i,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [31:0]                    wdata,
  output logic [31:0]                    rdata_o,
  output logic                           upd_o,
  output logic [NUM_CPUS*NUM_SHARED-1:0] target_map_o,
  output logic [NUM_SHARED*8-1:0]        cpu_idx_o
);
  localparam int SH_IW  = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;
  localparam int CPU_IW = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam idx_t NCPU = idx_t'(NUM_CPUS);

  aff_t                  aff_q [NUM_SHARED];
  idx_t                  idx_q [NUM_SHARED];
  logic [NUM_SHARED-1:0] map_q [NUM_CPUS];

  logic [SH_IW-1:0] slot;
  logic             hi_half;
  logic             in_range;
  logic             wr_ok;
  logic             hit;
  idx_t             hit_idx;
  idx_t             old_idx;
  logic             old_valid;

  rt_addr_dec #(
    .ADDR_W    (ADDR_W),
    .NUM_SHARED(NUM_SHARED),
    .SH_IW     (SH_IW)
  ) u_dec (
    .addr    (addr),
    .slot    (slot),
    .hi_half (hi_half),
    .in_range(in_range)
  );

  rt_aff_match #(
    .NUM_CPUS(NUM_CPUS)
  ) u_match (
    .key    (wdata),
    .table_i(cpu_aff_i),
    .hit    (hit),
    .idx    (hit_idx)
  );

  assign wr_ok     = wr_en && in_range && !hi_half;
  assign old_idx   = idx_q[slot];
  assign old_valid = (old_idx < NCPU);

  // affinity and index storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SHARED; s++) begin
        aff_q[s] <= cpu_aff_i[AFF_W-1:0];
        idx_q[s] <= '0;
      end
    end else if (wr_ok) begin
      aff_q[slot] <= wdata;
      idx_q[slot] <= hit ? hit_idx : IDX_NONE;
    end
  end

  // per-CPU target bitmaps: clear old owner first, the set below wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CPUS; c++) begin
        map_q[c] <= (c == 0) ? '1 : '0;
      end
    end else if (wr_ok) begin
      if (old_valid) map_q[old_idx[CPU_IW-1:0]][slot] <= 1'b0;
      if (hit)       map_q[hit_idx[CPU_IW-1:0]][slot] <= 1'b1;
    end
  end

  // read port and update strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      upd_o   <= 1'b0;
    end else begin
      upd_o <= wr_ok;
      if (rd_en) rdata_o <= (in_range && !hi_half) ? aff_q[slot] : '0;
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_map_out
    assign target_map_o[c*NUM_SHARED +: NUM_SHARED] = map_q[c];
  end

  for (genvar s = 0; s < NUM_SHARED; s++) begin : g_idx_out
    assign cpu_idx_o[s*IDX_W +: IDX_W] = idx_q[s];
  end
endmodule

// File: rtl/rt_route_chk.sv
module rt_route_chk #(
  parameter int NUM_SHARED = 32,
  parameter int NUM_CPUS   = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           wr_en,
  input logic                           rd_en,
  input logic                           hi_sel,
  input logic [31:0]                    rdata_o,
  input logic                           upd_o,
  input logic [NUM_CPUS*NUM_SHARED-1:0] target_map_o,
  input logic [NUM_SHARED*8-1:0]        cpu_idx_o
);
  localparam logic [NUM_CPUS-1:0] ONE = NUM_CPUS'(1);

  // R7
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> ($past(wr_en) && !$past(hi_sel)));

  // R3
  hi_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && hi_sel) |=> (rdata_o == 32'd0));

  // R3
  hi_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hi_sel) |=> !upd_o);

  // R4
  map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(target_map_o) && $stable(cpu_idx_o)));

  for (genvar s = 0; s < NUM_SHARED; s++) begin : g_spi
    logic [NUM_CPUS-1:0] col;
    logic [7:0]          idx;
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_col
      assign col[c] = target_map_o[c*NUM_SHARED + s];
    end
    assign idx = cpu_idx_o[s*8 +: 8];

    // R9
    single_owner_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col));

    // R9
    owner_match_chk: assert property (@(posedge clk) disable iff (rst)
      (idx != 8'hFF) |-> ((col >> idx) == ONE));

    // R5
    nobody_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (idx == 8'hFF) |-> (col == '0));
  end
endmodule

bind spi_route_table rt_route_chk #(
  .NUM_SHARED(NUM_SHARED),
  .NUM_CPUS  (NUM_CPUS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .hi_sel      (addr[2]),
  .rdata_o     (rdata_o),
  .upd_o       (upd_o),
  .target_map_o(target_map_o),
  .cpu_idx_o   (cpu_idx_o)
);

// File: tb/sim_spi_route_table.sv
`timescale 1ns/1ps
module sim_spi_route_table;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam int AW = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NC*32-1:0] cpu_aff;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata_o;
  logic            upd_o;
  logic [NC*NS-1:0] target_map_o;
  logic [NS*8-1:0] cpu_idx_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  logic [31:0] exp_aff [NS];
  logic [7:0]  exp_idx [NS];

  // CPU0 0x100, CPU1 0x101, CPU2 0x10000, CPU3 0x101 (duplicate of CPU1)
  assign cpu_aff = {32'h0000_0101, 32'h0001_0000, 32'h0000_0101, 32'h0000_0100};

  always #2 clk = ~clk;

  spi_route_table #(.NUM_SHARED(NS), .NUM_CPUS(NC), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .cpu_aff_i(cpu_aff), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata_o(rdata_o), .upd_o(upd_o),
    .target_map_o(target_map_o), .cpu_idx_o(cpu_idx_o)
  );

  // vector: [51:40] byte offset, [39:8] affinity written, [7:0] expected index
  localparam logic [51:0] VEC [8] = '{
    {12'h000, 32'h0000_0101, 8'h01},
    {12'h008, 32'h0001_0000, 8'h02},
    {12'h0F8, 32'h0000_DEAD, 8'hFF},
    {12'h000, 32'h0000_0100, 8'h00},
    {12'h010, 32'h0000_0101, 8'h01},
    {12'h018, 32'h0001_0001, 8'hFF},
    {12'h018, 32'h0001_0000, 8'h02},
    {12'h008, 32'h0001_0000, 8'h02}
  };

  function automatic logic [NC*NS-1:0] model_map();
    logic [NC*NS-1:0] m = '0;
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++)
        if (exp_idx[s] == 8'(c)) m[c*NS + s] = 1'b1;
    return m;
  endfunction

  function automatic logic [NS*8-1:0] model_idx();
    logic [NS*8-1:0] v;
    for (int s = 0; s < NS; s++) v[s*8 +: 8] = exp_idx[s];
    return v;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata_o;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    for (int s = 0; s < NS; s++) begin
      exp_aff[s] = 32'h0000_0100;
      exp_idx[s] = 8'h00;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 map", 256'(target_map_o), 256'(model_map()));
    check("R1 idx", 256'(cpu_idx_o), 256'(model_idx()));
    check("R1 upd", 256'(upd_o), 256'(0));
    do_read(12'h000, rd); check("R1 entry0", 256'(rd), 256'(32'h100));
    do_read(12'h0F8, rd); check("R1 entry31", 256'(rd), 256'(32'h100));

    // vector table walk: R2 R4 R5 R6 R7 R9 R10
    for (int v = 0; v < 8; v++) begin
      logic [11:0] va;
      logic [31:0] vd;
      logic [7:0]  vi;
      int          sl;
      va = VEC[v][51:40]; vd = VEC[v][39:8]; vi = VEC[v][7:0];
      sl = int'(va[11:3]);
      exp_aff[sl] = vd;
      exp_idx[sl] = vi;
      do_write(va, vd);
      check("R7 strobe high", 256'(upd_o), 256'(1));
      check((vi == 8'hFF) ? "R5 idx" : ((v == 4) ? "R6 idx" : "R4 idx"),
            256'(cpu_idx_o[sl*8 +: 8]), 256'(vi));
      check((v == 7) ? "R10 map" : "R9 map", 256'(target_map_o), 256'(model_map()));
      @(negedge clk);
      check("R7 strobe low", 256'(upd_o), 256'(0));
      do_read(va, rd);
      check((vi == 8'hFF) ? "R5 readback" : "R2 readback", 256'(rd), 256'(vd));
    end

    // R3 upper half write ignored, reads zero
    do_write(12'h004, 32'hFFFF_FFFF);
    check("R3 no strobe", 256'(upd_o), 256'(0));
    check("R3 map", 256'(target_map_o), 256'(model_map()));
    do_read(12'h004, rd); check("R3 read zero", 256'(rd), 256'(0));
    do_read(12'h000, rd); check("R3 lower kept", 256'(rd), 256'(exp_aff[0]));

    // R8 beyond last entry
    do_write(12'h100, 32'h0000_0101);
    check("R8 no strobe", 256'(upd_o), 256'(0));
    check("R8 idx", 256'(cpu_idx_o), 256'(model_idx()));
    check("R8 map", 256'(target_map_o), 256'(model_map()));
    do_read(12'h100, rd); check("R8 read zero", 256'(rd), 256'(0));

    // R4 last entry moves from nobody to CPU2, then back to CPU0
    exp_aff[31] = 32'h0001_0000; exp_idx[31] = 8'h02;
    do_write(12'h0F8, 32'h0001_0000);
    check("R4 map last", 256'(target_map_o), 256'(model_map()));
    exp_aff[31] = 32'h0000_0100; exp_idx[31] = 8'h00;
    do_write(12'h0F8, 32'h0000_0100);
    check("R4 map back", 256'(target_map_o), 256'(model_map()));
    check("R4 idx all", 256'(cpu_idx_o), 256'(model_idx()));

    done = 1'b1;
    finish_run();
  end
endmodule